// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Enforcer

This block sits between an SDRAM controller's command scheduler and the memory command pins. The scheduler presents one candidate command per clock: activate a row, read, write, precharge or auto refresh, together with a bank and a row address. In the same clock the block answers whether that command may go out. Accepted commands update the per-bank state and timers on the clock edge that ends the cycle. Refused commands stall and leave every bank exactly as it was.

For each of four banks the block tracks whether a row is open and which row it is. It also keeps a row-to-column countdown and a row-cycle countdown for each bank. One countdown shared by all banks spaces activates to different banks. The minimum delays are given as picosecond parameters and become whole clock counts by rounding up against the clock period.

A separate deadline timer raises a refresh request once the refresh interval has passed since the last auto refresh or the last exit from self refresh. That interval is rounded down to whole clocks. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `sdram_act_guard`

## Requirements
- R1: A read (code 2) or write (code 3) to a bank whose open flag is clear is refused.
- R2: A read or write to a bank is granted no earlier than T_RCD clocks after that bank's activate, where T_RCD = ceil(TRCD_PS / CLK_PS) (3 by default). Earlier requests are refused.
- R3: An activate (code 1) to a bank that already holds an open row is refused until a precharge has closed it.
- R4: Two activates to the same bank are at least T_RC = ceil(TRC_PS / CLK_PS) clocks apart (10 by default).
- R5: Activates to any two banks are at least T_RRD = ceil(TRRD_PS / CLK_PS) clocks apart (2 by default). Reads and writes to other banks are unaffected by this spacing.
- R6: A precharge (code 4) is always granted and leaves the addressed bank's open flag clear.
- R7: An auto refresh (code 5) is granted only while `bank_open` is zero. A granted auto refresh restarts the refresh deadline.
- R8: `refresh_due` goes high exactly T_REFI = floor(REFI_PS / CLK_PS) clocks after the edge that restarts the deadline (1953 by default). It stays high until a granted auto refresh or a `sr_exit` pulse restarts it. After a restart it is low on the next cycle.
- R9: A refused command raises `stall`, keeps `grant` low, and leaves `bank_open` and every stored row unchanged. `grant` and `stall` are never high together.
- R10: With `req_valid` low, both `grant` and `stall` are low. A valid request with code 0, 6 or 7 is refused.
- R11: `bank_open` bit n is the open flag of bank n. `cur_row` shows the row latched by the most recent granted activate to bank `req_bank`.
- R12: During and after reset, all banks are closed, `grant` and `stall` are low and `refresh_due` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Candidate command present |
| req_cmd | input | 3 | Command code: 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address for an activate |
| sr_exit | input | 1 | One-cycle pulse on leaving self refresh |
| grant | output | 1 | Command may issue this clock |
| stall | output | 1 | Command refused this clock |
| bank_open | output | 4 | Open flag per bank |
| cur_row | output | 12 | Stored row of bank `req_bank` |
| refresh_due | output | 1 | Refresh deadline reached |

## Verification
The hardest situation to reach is a refused activate that is blocked for only one reason while the other spacing rules are already met. One example is a same-bank activate that has satisfied the bank-to-bank spacing but not the row-cycle count. Another is the reverse: a fresh bank blocked only by a neighbour's recent activate. The vector table reaches both by spacing activates across four banks in a set order. It closes one bank shortly after opening it, then retries the activate at offsets just below and exactly at the row-cycle limit. The refresh deadline is reached by idling for the full interval after a granted auto refresh, sampling one clock short of the deadline and at it.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // whole clocks covering a minimum delay
  function automatic int clk_ceil(input int dly_ps, input int per_ps);
    return (dly_ps + per_ps - 1) / per_ps;
  endfunction

  // whole clocks that never exceed a maximum interval
  function automatic int clk_floor(input int dly_ps, input int per_ps);
    return dly_ps / per_ps;
  endfunction

endpackage

// File: rtl/act_bank_state.sv
module act_bank_state #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 3,
  parameter int T_RC  = 10
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_rdwr,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok,
  output logic             rdwr_ok
);

  localparam int RCD_W = $clog2(T_RCD + 1);
  localparam int RC_W  = $clog2(T_RC + 1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic [RCD_W-1:0] rcd_q, rcd_d;
  logic [RC_W-1:0]  rc_q, rc_d;

  always_comb begin
    open_d = open_q;
    if (do_act)      open_d = 1'b1;
    else if (do_pre) open_d = 1'b0;

    rcd_d = rcd_q;
    if (do_act)              rcd_d = RCD_W'(T_RCD - 1);
    else if (rcd_q != '0)    rcd_d = rcd_q - 1'b1;

    rc_d = rc_q;
    if (do_act)              rc_d = RC_W'(T_RC - 1);
    else if (rc_q != '0)     rc_d = rc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rc_q   <= '0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      rcd_q  <= rcd_d;
      rc_q   <= rc_d;
      if (do_act) row_q <= row_in;
    end
  end

  assign open_o  = open_q;
  assign row_o   = row_q;
  assign act_ok  = !open_q && (rc_q == '0);
  assign rdwr_ok = open_q && (rcd_q == '0);

  // independent age counter for the checks below
  logic [RC_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                      since_q <= RC_W'(T_RC);
    else if (do_act)                  since_q <= RC_W'(1);
    else if (since_q != RC_W'(T_RC))  since_q <= since_q + 1'b1;
  end

  // R1
  rdwr_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    do_rdwr |-> open_q);
  // R2
  rdwr_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    do_rdwr |-> (since_q >= RC_W'(T_RCD)));
  // R3
  act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    do_act |-> !open_q);
  // R4
  act_after_rc_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    do_act |-> (since_q >= RC_W'(T_RC)));
  // R6
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    do_pre |=> !open_q);
  // R9
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(do_act || do_pre) |=> ($stable(open_q) && $stable(row_q)));

endmodule

// File: rtl/act_spacing.sv
module act_spacing #(
  parameter int T_RRD = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic any_act,
  output logic rrd_ok
);

  localparam int RRD_W = $clog2(T_RRD + 1);

  logic [RRD_W-1:0] rrd_q, rrd_d;

  always_comb begin
    rrd_d = rrd_q;
    if (any_act)            rrd_d = RRD_W'(T_RRD - 1);
    else if (rrd_q != '0)   rrd_d = rrd_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rrd_q <= '0;
    else         rrd_q <= rrd_d;
  end

  assign rrd_ok = (rrd_q == '0);

  logic [RRD_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                        since_q <= RRD_W'(T_RRD);
    else if (any_act)                   since_q <= RRD_W'(1);
    else if (since_q != RRD_W'(T_RRD))  since_q <= since_q + 1'b1;
  end

  // R5
  act_to_act_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    any_act |-> (since_q >= RRD_W'(T_RRD)));

endmodule

// File: rtl/refresh_deadline.sv
module refresh_deadline #(
  parameter int T_REFI = 1953
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic restart,
  output logic due
);

  localparam int CNT_W = $clog2(T_REFI + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)            cnt_d = CNT_W'(T_REFI - 1);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= CNT_W'(T_REFI - 1);
    else         cnt_q <= cnt_d;
  end

  assign due = (cnt_q == '0);

  // R8
  due_drops_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(due) |-> $past(restart));
  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    restart |=> !due);

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sdram_act_pkg::*;
#(
  parameter int NB       = 4,
  parameter int ROW_W    = 12,
  parameter int CLK_PS   = 8000,
  parameter int TRCD_PS  = 20000,
  parameter int TRC_PS   = 80000,
  parameter int TRRD_PS  = 16000,
  parameter int REFI_PS  = 15625000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_cmd,
  input  logic [$clog2(NB)-1:0]  req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic                   sr_exit,
  output logic                   grant,
  output logic                   stall,
  output logic [NB-1:0]          bank_open,
  output logic [ROW_W-1:0]       cur_row,
  output logic                   refresh_due
);

  localparam int T_RCD  = clk_ceil(TRCD_PS, CLK_PS);
  localparam int T_RC   = clk_ceil(TRC_PS, CLK_PS);
  localparam int T_RRD  = clk_ceil(TRRD_PS, CLK_PS);
  localparam int T_REFI = clk_floor(REFI_PS, CLK_PS);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic [NB-1:0]    act_ok, rdwr_ok, sel;
  logic [NB-1:0]    b_act, b_pre, b_rdwr;
  logic [ROW_W-1:0] row_vec [NB];
  logic             rrd_ok, allowed;
  logic             acc_act, acc_pre, acc_rdwr, acc_ref;

  always_comb begin
    allowed = 1'b0;
    unique case (req_cmd)
      CMD_ACT: allowed = act_ok[req_bank] && rrd_ok;
      CMD_RD,
      CMD_WR:  allowed = rdwr_ok[req_bank];
      CMD_PRE: allowed = 1'b1;
      CMD_REF: allowed = (bank_open == '0);
      default: allowed = 1'b0;
    endcase
  end

  assign grant    = req_valid && allowed;
  assign stall    = req_valid && !allowed;
  assign acc_act  = grant && (req_cmd == CMD_ACT);
  assign acc_pre  = grant && (req_cmd == CMD_PRE);
  assign acc_rdwr = grant && ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));
  assign acc_ref  = grant && (req_cmd == CMD_REF);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign sel[g]    = (req_bank == g[$clog2(NB)-1:0]);
    assign b_act[g]  = acc_act  && sel[g];
    assign b_pre[g]  = acc_pre  && sel[g];
    assign b_rdwr[g] = acc_rdwr && sel[g];

    act_bank_state #(
      .ROW_W (ROW_W),
      .T_RCD (T_RCD),
      .T_RC  (T_RC)
    ) u_bank (
      .clk     (clk),
      .rst_sn  (rst_sn),
      .do_act  (b_act[g]),
      .do_pre  (b_pre[g]),
      .do_rdwr (b_rdwr[g]),
      .row_in  (req_row),
      .open_o  (bank_open[g]),
      .row_o   (row_vec[g]),
      .act_ok  (act_ok[g]),
      .rdwr_ok (rdwr_ok[g])
    );
  end

  act_spacing #(.T_RRD(T_RRD)) u_rrd (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .any_act (acc_act),
    .rrd_ok  (rrd_ok)
  );

  refresh_deadline #(.T_REFI(T_REFI)) u_refi (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .restart (acc_ref || sr_exit),
    .due     (refresh_due)
  );

  assign cur_row = row_vec[req_bank];

  // R9
  grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(grant && stall));
  // R7
  ref_with_closed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_ref |=> (bank_open == '0));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid |-> (!grant && !stall));
  // R12
  reset_closed_chk: assert property (@(posedge clk)
    !rst_sn |-> (bank_open == '0));

endmodule

// File: tb/sim_sdram_act_guard.sv
module sim_sdram_act_guard;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_cmd;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic        sr_exit;
  logic        grant, stall, refresh_due;
  logic [3:0]  bank_open;
  logic [11:0] cur_row;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  sdram_act_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .sr_exit(sr_exit),
    .grant(grant), .stall(stall), .bank_open(bank_open),
    .cur_row(cur_row), .refresh_due(refresh_due)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns later, commit on the next rise
  task automatic drive(input logic v, input logic [2:0] c, input logic [1:0] b,
                       input logic [11:0] r);
    @(negedge clk);
    req_valid = v; req_cmd = c; req_bank = b; req_row = r; sr_exit = 1'b0;
    #1;
  endtask

  // {valid, cmd, bank, row, expected grant}
  localparam logic [18:0] VEC [20] = '{
    {1'b1, 3'd1, 2'd0, 12'h123, 1'b1},  // 0  act b0
    {1'b1, 3'd2, 2'd0, 12'h000, 1'b0},  // 1  R2 rd too early
    {1'b1, 3'd1, 2'd1, 12'h0AA, 1'b1},  // 2  R5 act b1 at spacing 2
    {1'b1, 3'd2, 2'd0, 12'h000, 1'b1},  // 3  R2 rd at 3
    {1'b1, 3'd3, 2'd1, 12'h000, 1'b0},  // 4  R2 wr too early
    {1'b1, 3'd1, 2'd2, 12'h7FF, 1'b1},  // 5  act b2
    {1'b1, 3'd1, 2'd3, 12'h456, 1'b0},  // 6  R5 act too close
    {1'b1, 3'd1, 2'd3, 12'h456, 1'b1},  // 7  R5 act at spacing
    {1'b1, 3'd3, 2'd1, 12'h000, 1'b1},  // 8  wr b1
    {1'b1, 3'd1, 2'd0, 12'h999, 1'b0},  // 9  R3 act on open bank
    {1'b1, 3'd5, 2'd0, 12'h000, 1'b0},  // 10 R7 ref with open banks
    {1'b1, 3'd4, 2'd0, 12'h000, 1'b1},  // 11 R6 pre b0
    {1'b1, 3'd1, 2'd0, 12'h3C5, 1'b1},  // 12 act b0 again
    {1'b1, 3'd4, 2'd3, 12'h000, 1'b1},  // 13 pre b3
    {1'b1, 3'd1, 2'd3, 12'h222, 1'b0},  // 14 R4 row cycle 7
    {1'b0, 3'd1, 2'd3, 12'h222, 1'b0},  // 15 R10 not valid
    {1'b1, 3'd1, 2'd3, 12'h222, 1'b0},  // 16 R4 row cycle 9
    {1'b1, 3'd1, 2'd3, 12'h001, 1'b1},  // 17 R4 row cycle 10
    {1'b1, 3'd2, 2'd2, 12'h000, 1'b1},  // 18 rd b2
    {1'b1, 3'd6, 2'd0, 12'h000, 1'b0}   // 19 R10 unused code
  };

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_fail++;
          n_run++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none

    rst_n = 1'b0; req_valid = 1'b0; req_cmd = 3'd0; req_bank = 2'd0;
    req_row = '0; sr_exit = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R12
    check(bank_open == 4'h0, "R12 banks closed in reset", bank_open, 0);
    check(!grant && !stall && !refresh_due, "R12 outputs low in reset",
          {grant, stall, refresh_due}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) drive(1'b0, 3'd0, 2'd0, 12'h0);

    for (int i = 0; i < 20; i++) begin
      logic [18:0] e;
      logic eg;
      e  = VEC[i];
      eg = e[0];
      drive(e[18], e[17:15], e[14:13], e[12:1]);
      check(grant == eg, $sformatf("R1-table grant step %0d", i), grant, eg);
      check(stall == (e[18] && !eg), $sformatf("R9 stall step %0d", i), stall,
            e[18] && !eg);
    end

    // R11 row and open reporting
    drive(1'b0, 3'd0, 2'd1, 12'h0);
    check(bank_open == 4'hF, "R11 all banks open", bank_open, 4'hF);
    check(cur_row == 12'h0AA, "R11 row bank1", cur_row, 12'h0AA);
    drive(1'b0, 3'd0, 2'd0, 12'h0);
    check(cur_row == 12'h3C5, "R11 row bank0 after reopen", cur_row, 12'h3C5);

    // R9 refused command leaves state
    drive(1'b1, 3'd1, 2'd1, 12'h555);
    check(stall && !grant, "R9 refused act stalls", {stall, grant}, 2'b10);
    drive(1'b0, 3'd0, 2'd1, 12'h0);
    check(cur_row == 12'h0AA, "R9 row unchanged", cur_row, 12'h0AA);
    check(bank_open == 4'hF, "R9 open flags unchanged", bank_open, 4'hF);

    // R6 precharge closes, R1 read to closed bank
    drive(1'b1, 3'd4, 2'd1, 12'h0);
    check(grant, "R6 pre granted", grant, 1);
    drive(1'b1, 3'd2, 2'd1, 12'h0);
    check(bank_open == 4'b1101, "R6 bank1 closed", bank_open, 4'b1101);
    check(stall, "R1 rd to closed bank refused", stall, 1);
    drive(1'b1, 3'd4, 2'd1, 12'h0);
    check(grant, "R6 pre on closed bank granted", grant, 1);

    drive(1'b1, 3'd4, 2'd0, 12'h0);
    drive(1'b1, 3'd4, 2'd2, 12'h0);
    drive(1'b1, 3'd4, 2'd3, 12'h0);
    drive(1'b1, 3'd5, 2'd0, 12'h0);
    check(bank_open == 4'h0, "R7 all closed before ref", bank_open, 0);
    check(grant, "R7 ref granted when closed", grant, 1);

    // R8 deadline measured from the granted refresh
    for (int j = 1; j <= 1953; j++) begin
      drive(1'b0, 3'd0, 2'd0, 12'h0);
      if (j == 1)    check(!refresh_due, "R8 low after restart", refresh_due, 0);
      if (j == 1952) check(!refresh_due, "R8 low one clock early", refresh_due, 0);
      if (j == 1953) check(refresh_due, "R8 high at deadline", refresh_due, 1);
    end
    drive(1'b0, 3'd0, 2'd0, 12'h0);
    check(refresh_due, "R8 stays high", refresh_due, 1);
    @(negedge clk); sr_exit = 1'b1; #1;
    drive(1'b0, 3'd0, 2'd0, 12'h0);
    check(!refresh_due, "R8 self refresh exit restarts", refresh_due, 0);

    // R12 reset in mid run
    drive(1'b1, 3'd1, 2'd2, 12'h0);
    check(grant, "R12 act before reset", grant, 1);
    @(negedge clk); req_valid = 1'b0; rst_n = 1'b0; #1;
    check(bank_open == 4'h0, "R12 reset closes banks", bank_open, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drive(1'b0, 3'd0, 2'd0, 12'h0);
    check(bank_open == 4'h0 && !refresh_due, "R12 clean after reset",
          {bank_open, refresh_due}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule